// File: doc/BRIEF.md
# Ethernet Port Interrupt Controller with Receive Coalescing

This block gathers the event strobes of a fast Ethernet MAC port into a raw status word and turns them into one level-sensitive interrupt line for the host CPU. Status bits are sticky and are cleared by writing ones. An enable word masks each source and also holds two gates, one for the port and one global. The interrupt line rises only when a source is unmasked and both gates are open.

Received frames are also counted in a pending counter. Software consumes one frame each time it clears the receive-ready bit, and the bit comes back while frames remain. A coalescing stage raises a separate "several frames ready" bit. It sets once the pending count reaches a programmed threshold. It also sets when a tick-driven timeout, which starts with the first pending frame, expires while frames are still waiting. This lets software take one interrupt per burst instead of one per frame.

Access is through a simple word-addressed register port with a synchronous write strobe and a combinational read. Word 0 holds status, word 1 holds enable, word 2 holds the coalescing configuration, and word 3 reads zero.

Top module: `eth_irq_ctrl`

## Requirements
- R1: After reset every register is zero: all three words read 0 and the interrupt line is low.
- R2: Status bit 1 (transmit packet done) and bit 6 (transmit FIFO empty) set one cycle after their strobe and stay set until a write to word 0 has a one in that position; a zero in the written data leaves a bit unchanged, and bits 5:2 always read zero whatever is written.
- R3: When a strobe and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R4: Each receive strobe adds one to a pending-frame count. Status bit 0 reads one exactly when that count is nonzero. A write to word 0 with bit 0 set removes one pending frame, so bit 0 sets again in the next cycle if frames remain.
- R5: Word 1 stores the source masks in bits 7:0, the port gate in bit 18 and the global gate in bit 19; all other bits read zero.
- R6: The interrupt line is high exactly when (status[7:0] AND mask[7:0]) is nonzero and both the port gate and the global gate are set.
- R7: Status bit 7 sets when the pending count, after the current cycle's updates, is at or above a nonzero threshold; a threshold of zero disables this path.
- R8: A timeout counter advances once per cycle with the tick input high, while frames are pending and status bit 7 is clear. Bit 7 sets on the tick that brings the count to a nonzero timeout value. The counter restarts from zero when bit 7 is cleared by software or when no frame is pending; a timeout of zero disables this path.
- R9: Word 2 stores the frame-count threshold in bits 31:24 and the timeout in bits 15:0; bits 23:16 read zero.
- R10: The pending count saturates at its maximum (255 by default); further receive strobes are lost, and exactly that many bit-0 clears empty it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_frame_i | input | 1 | One-cycle strobe: a frame has been received |
| tx_done_i | input | 1 | One-cycle strobe: a packet has been transmitted |
| tx_empty_i | input | 1 | One-cycle strobe: transmit FIFO ran empty |
| tick_i | input | 1 | Prescaled enable that paces the coalescing timeout |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word select: 0 status, 1 enable, 2 coalescing, 3 spare |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected word (combinational) |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
On every cycle the assertions check several properties. The line never rises with a gate closed. A receive or transmit strobe always leaves its bit set in the next cycle. A write-one-to-clear without a competing strobe drops the transmit-done bit. A stable threshold that the pending count has reached always shows in bit 7, and a saturated count stays saturated. Other behaviour can only be seen in the bench's scenarios. This covers the exact tick on which the timeout fires and its restart after a clear. It also covers the re-setting of bit 0 while frames remain, the draining of a saturated count, and the read-back layout of each word. The bench compares each of these against a cycle model on every cycle.

// File: rtl/eic_pkg.sv
package eic_pkg;

  // Register data width and field positions that software decodes.
  localparam int unsigned REG_W         = 32;
  localparam int unsigned NSRC          = 8;
  localparam int unsigned ADDR_W        = 2;

  // Status bit positions.
  localparam int unsigned SRC_RX_RDY    = 0;
  localparam int unsigned SRC_TX_DONE   = 1;
  localparam int unsigned SRC_TX_EMPTY  = 6;
  localparam int unsigned SRC_RX_MULTI  = 7;
  localparam logic [NSRC-1:0] SRC_STICKY = 8'b1100_0010;

  // Enable word gates and coalescing field.
  localparam int unsigned EN_PORT_POS   = 18;
  localparam int unsigned EN_GLOBAL_POS = 19;
  localparam int unsigned THR_W         = 8;
  localparam int unsigned THR_LSB       = REG_W - THR_W;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS   = 2'd0,
    SEL_ENABLE   = 2'd1,
    SEL_COALESCE = 2'd2,
    SEL_SPARE    = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic            glob;
    logic            port;
    logic [NSRC-1:0] mask;
  } enable_t;

endpackage

// File: rtl/eic_rst_sync.sv
module eic_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/eic_regif.sv
module eic_regif
  import eic_pkg::*;
#(
  parameter int unsigned TMO_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic [NSRC-1:0]      raw_i,
  output logic [NSRC-1:0]      clr_o,
  output enable_t              en_o,
  output logic [THR_W-1:0]     thr_o,
  output logic [TMO_W-1:0]     tmo_o,
  output logic [REG_W-1:0]     rdata_o
);

  reg_sel_e         sel;
  logic             wr_status;
  logic             wr_enable;
  logic             wr_coal;
  enable_t          en_q, en_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic             unused_wdata;

  assign sel       = reg_sel_e'(addr_i);
  assign wr_status = wr_i && (sel == SEL_STATUS);
  assign wr_enable = wr_i && (sel == SEL_ENABLE);
  assign wr_coal   = wr_i && (sel == SEL_COALESCE);

  // Clear vector for the status bank: ones written to the status word.
  assign clr_o = wr_status ? wdata_i[NSRC-1:0] : '0;

  always_comb begin
    en_d  = en_q;
    thr_d = thr_q;
    tmo_d = tmo_q;
    if (wr_enable) begin
      en_d.mask = wdata_i[NSRC-1:0];
      en_d.port = wdata_i[EN_PORT_POS];
      en_d.glob = wdata_i[EN_GLOBAL_POS];
    end
    if (wr_coal) begin
      thr_d = wdata_i[THR_LSB +: THR_W];
      tmo_d = wdata_i[TMO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      thr_q <= '0;
      tmo_q <= '0;
    end else begin
      if (wr_enable) en_q <= en_d;
      if (wr_coal) begin
        thr_q <= thr_d;
        tmo_q <= tmo_d;
      end
    end
  end

  // Combinational read mux.
  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_STATUS:   rdata_o[NSRC-1:0] = raw_i;
      SEL_ENABLE: begin
        rdata_o[NSRC-1:0]     = en_q.mask;
        rdata_o[EN_PORT_POS]   = en_q.port;
        rdata_o[EN_GLOBAL_POS] = en_q.glob;
      end
      SEL_COALESCE: begin
        rdata_o[THR_LSB +: THR_W] = thr_q;
        rdata_o[TMO_W-1:0]        = tmo_q;
      end
      SEL_SPARE:    rdata_o = '0;
      default:      rdata_o = '0;
    endcase
  end

  assign en_o  = en_q;
  assign thr_o = thr_q;
  assign tmo_o = tmo_q;

  assign unused_wdata = &{1'b0, wdata_i};

endmodule

// File: rtl/eic_coalesce.sv
module eic_coalesce
  import eic_pkg::*;
#(
  parameter int unsigned PEND_W = 8,
  parameter int unsigned TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_evt_i,
  input  logic              take_i,
  input  logic              clr_multi_i,
  input  logic              tick_i,
  input  logic              multi_q_i,
  input  logic [THR_W-1:0]  thr_i,
  input  logic [TMO_W-1:0]  tmo_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              pend_nz_d_o,
  output logic              multi_set_o
);

  localparam int unsigned CMP_W = (PEND_W > THR_W) ? PEND_W : THR_W;
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};
  localparam logic [TMO_W-1:0]  TMR_MAX  = {TMO_W{1'b1}};

  logic [PEND_W-1:0] pend_q, pend_d;
  logic [TMO_W-1:0]  tmr_q, tmr_d;
  logic              inc, dec;
  logic              tmr_run;
  logic              tmr_fire;
  logic              thr_hit;
  logic [TMO_W:0]    tmr_plus;

  // Pending-frame counter: saturating up, floored down.
  assign inc = rx_evt_i && (pend_q != PEND_MAX);
  assign dec = take_i && (pend_q != '0);

  always_comb begin
    pend_d = pend_q;
    case ({inc, dec})
      2'b10:   pend_d = pend_q + 1'b1;
      2'b01:   pend_d = pend_q - 1'b1;
      default: pend_d = pend_q;
    endcase
  end

  // Timeout counter runs while frames wait and no coalesced event is up.
  assign tmr_run  = (pend_q != '0) && !multi_q_i;
  assign tmr_plus = {1'b0, tmr_q} + 1'b1;
  assign tmr_fire = tmr_run && tick_i && (tmo_i != '0) &&
                    (tmr_plus == {1'b0, tmo_i});

  always_comb begin
    tmr_d = tmr_q;
    if (clr_multi_i || !tmr_run) begin
      tmr_d = '0;
    end else if (tick_i && (tmr_q != TMR_MAX)) begin
      tmr_d = tmr_plus[TMO_W-1:0];
    end
  end

  assign thr_hit = (thr_i != '0) &&
                   (CMP_W'(pend_d) >= CMP_W'(thr_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      tmr_q  <= '0;
    end else begin
      pend_q <= pend_d;
      tmr_q  <= tmr_d;
    end
  end

  assign pend_o      = pend_q;
  assign pend_nz_d_o = (pend_d != '0);
  assign multi_set_o = thr_hit || tmr_fire;

endmodule

// File: rtl/eic_status.sv
module eic_status
  import eic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_level_i,
  input  logic            tx_done_i,
  input  logic            tx_empty_i,
  input  logic            multi_set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] raw_o
);

  logic [NSRC-1:0] set_vec;
  logic            unused_clr;

  always_comb begin
    set_vec               = '0;
    set_vec[SRC_TX_DONE]  = tx_done_i;
    set_vec[SRC_TX_EMPTY] = tx_empty_i;
    set_vec[SRC_RX_MULTI] = multi_set_i;
  end

  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    if (b == SRC_RX_RDY) begin : g_level
      // Follows the pending count; a clear re-arms it if frames remain.
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= rx_level_i;
      end
      assign raw_o[b] = q;
    end else if (SRC_STICKY[b]) begin : g_sticky
      logic q, d;
      always_comb begin
        d = set_vec[b] || (q && !clr_i[b]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
      end
      assign raw_o[b] = q;
    end else begin : g_reserved
      assign raw_o[b] = 1'b0;
    end
  end

  assign unused_clr = &{1'b0, clr_i, set_vec};

endmodule

// File: rtl/eth_irq_ctrl.sv
module eth_irq_ctrl
  import eic_pkg::*;
#(
  parameter int unsigned PEND_W = 8,
  parameter int unsigned TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_frame_i,
  input  logic              tx_done_i,
  input  logic              tx_empty_i,
  input  logic              tick_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);

  logic              rst_sync_n;
  logic [NSRC-1:0]   raw_q;
  logic [NSRC-1:0]   clr_vec;
  enable_t           en_q;
  logic [THR_W-1:0]  thr_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [PEND_W-1:0] pend_q;
  logic              pend_nz_d;
  logic              multi_set;

  eic_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  eic_regif #(.TMO_W(TMO_W)) u_regif (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .raw_i   (raw_q),
    .clr_o   (clr_vec),
    .en_o    (en_q),
    .thr_o   (thr_q),
    .tmo_o   (tmo_q),
    .rdata_o (reg_rdata_o)
  );

  eic_coalesce #(.PEND_W(PEND_W), .TMO_W(TMO_W)) u_coal (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rx_evt_i    (rx_frame_i),
    .take_i      (clr_vec[SRC_RX_RDY]),
    .clr_multi_i (clr_vec[SRC_RX_MULTI]),
    .tick_i      (tick_i),
    .multi_q_i   (raw_q[SRC_RX_MULTI]),
    .thr_i       (thr_q),
    .tmo_i       (tmo_q),
    .pend_o      (pend_q),
    .pend_nz_d_o (pend_nz_d),
    .multi_set_o (multi_set)
  );

  eic_status u_stat (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rx_level_i  (pend_nz_d),
    .tx_done_i   (tx_done_i),
    .tx_empty_i  (tx_empty_i),
    .multi_set_i (multi_set),
    .clr_i       (clr_vec),
    .raw_o       (raw_q)
  );

  // Three-level gating: per source, port, global.
  assign irq_o = (|(raw_q & en_q.mask)) && en_q.port && en_q.glob;

endmodule

// File: rtl/eic_checker.sv
module eic_checker
  import eic_pkg::*;
#(
  parameter int unsigned PEND_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic [NSRC-1:0]   raw,
  input logic              en_glob,
  input logic              en_port,
  input logic              rx_evt,
  input logic              tx_done,
  input logic              tx_empty,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wdata,
  input logic [PEND_W-1:0] pend,
  input logic [THR_W-1:0]  thr
);

  logic w1c;
  assign w1c = wr && (addr == SEL_STATUS);

  a_r6_gates_closed_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_glob && en_port));

  a_r4_rx_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> raw[SRC_RX_RDY]);

  a_r2_txdone_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> raw[SRC_TX_DONE]);

  a_r2_w1c_drops_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c && wdata[SRC_TX_DONE] && !tx_done) |=> !raw[SRC_TX_DONE]);

  a_r3_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c && wdata[SRC_TX_EMPTY] && tx_empty) |=> raw[SRC_TX_EMPTY]);

  a_r7_threshold_shown: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(thr) && (thr != '0) && ({{THR_W{1'b0}}, pend} >= {{PEND_W{1'b0}}, thr}))
      |-> raw[SRC_RX_MULTI]);

  a_r10_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend == {PEND_W{1'b1}}) && !(w1c && wdata[SRC_RX_RDY])) |=> (pend == {PEND_W{1'b1}}));

endmodule

bind eth_irq_ctrl eic_checker #(.PEND_W(PEND_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .irq      (irq_o),
  .raw      (raw_q),
  .en_glob  (en_q.glob),
  .en_port  (en_q.port),
  .rx_evt   (rx_frame_i),
  .tx_done  (tx_done_i),
  .tx_empty (tx_empty_i),
  .wr       (reg_wr_i),
  .addr     (reg_addr_i),
  .wdata    (reg_wdata_i),
  .pend     (pend_q),
  .thr      (thr_q)
);

// File: tb/eth_irq_ctrl_bench.sv
module eth_irq_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic        rx_frame_i, tx_done_i, tx_empty_i, tick_i;
  logic        reg_wr_i;
  logic [1:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  string cur_tag = "R1";

  // Cycle model state, built from the requirements.
  bit [7:0] m_raw, m_mask;
  bit       m_port, m_glob;
  int       m_thr, m_tmo, m_pend, m_timer;

  eth_irq_ctrl u_eth_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_frame_i(rx_frame_i), .tx_done_i(tx_done_i),
    .tx_empty_i(tx_empty_i), .tick_i(tick_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic bit [31:0] exp_rd(input bit [1:0] a);
    bit [31:0] v = 0;
    case (a)
      2'd0: v[7:0] = m_raw;                                   // R2 R4
      2'd1: begin v[7:0] = m_mask; v[18] = m_port; v[19] = m_glob; end // R5
      2'd2: begin v[31:24] = m_thr[7:0]; v[15:0] = m_tmo[15:0]; end    // R9
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic bit exp_irq();
    return (|(m_raw & m_mask)) && m_port && m_glob;             // R6
  endfunction

  task automatic model_step();
    bit [7:0] clr, nraw;
    bit inc, dec, run, fire, thit;
    int pn, tn;
    clr  = (reg_wr_i && reg_addr_i == 2'd0) ? reg_wdata_i[7:0] : 8'h00;
    inc  = rx_frame_i && (m_pend != 255);                        // R10
    dec  = clr[0] && (m_pend != 0);                              // R4
    pn   = m_pend + int'(inc) - int'(dec);
    run  = (m_pend != 0) && !m_raw[7];                           // R8
    fire = run && tick_i && (m_tmo != 0) && (m_timer + 1 == m_tmo);
    if (clr[7] || !run) tn = 0;
    else if (tick_i && m_timer != 65535) tn = m_timer + 1;
    else tn = m_timer;
    thit = (m_thr != 0) && (pn >= m_thr);                        // R7
    nraw    = 0;
    nraw[0] = (pn != 0);
    nraw[1] = tx_done_i  || (m_raw[1] && !clr[1]);               // R2 R3
    nraw[6] = tx_empty_i || (m_raw[6] && !clr[6]);
    nraw[7] = thit || fire || (m_raw[7] && !clr[7]);
    if (reg_wr_i && reg_addr_i == 2'd1) begin
      m_mask = reg_wdata_i[7:0]; m_port = reg_wdata_i[18]; m_glob = reg_wdata_i[19];
    end
    if (reg_wr_i && reg_addr_i == 2'd2) begin
      m_thr = int'(reg_wdata_i[31:24]); m_tmo = int'(reg_wdata_i[15:0]);
    end
    m_raw = nraw; m_pend = pn; m_timer = tn;
  endtask

  task automatic compare();
    bit [31:0] er;
    bit ei;
    er = exp_rd(reg_addr_i);
    ei = exp_irq();
    vectors++;
    if (reg_rdata_o !== er) begin
      errors++;
      $display("FAIL %s word%0d read got %h exp %h", cur_tag, reg_addr_i, reg_rdata_o, er);
    end
    vectors++;
    if (irq_o !== ei) begin
      errors++;
      $display("FAIL %s irq got %0d exp %0d", cur_tag, irq_o, ei);
    end
  endtask

  task automatic cyc(input bit wr, input bit [1:0] a, input bit [31:0] d,
                     input bit rx, input bit txd, input bit txe, input bit tk);
    @(negedge clk);
    compare();
    reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d;
    rx_frame_i = rx; tx_done_i = txd; tx_empty_i = txe; tick_i = tk;
    @(posedge clk);
    model_step();
  endtask

  task automatic rd(input bit [1:0] a);
    cyc(0, a, 0, 0, 0, 0, 0);
  endtask

  task automatic wrw(input bit [1:0] a, input bit [31:0] d);
    cyc(1, a, d, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1F2E3D4C);
    m_raw = 0; m_mask = 0; m_port = 0; m_glob = 0;
    m_thr = 0; m_tmo = 0; m_pend = 0; m_timer = 0;
    rst_n = 0; reg_wr_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
    rx_frame_i = 0; tx_done_i = 0; tx_empty_i = 0; tick_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R1: reset state of all words and the line.
    cur_tag = "R1";
    for (int a = 0; a < 4; a++) rd(2'(a));
    rd(0);

    // R5: enable word layout, unused bits read zero.
    cur_tag = "R5";
    wrw(1, 32'hFFFF_FFFF); rd(1); rd(3);
    wrw(1, 32'h000C_0042); rd(1);

    // R2: sticky transmit bits, zero-writes ignored, reserved bits stay zero.
    cur_tag = "R2";
    cyc(0, 0, 0, 0, 1, 0, 0); rd(0);
    wrw(0, 32'h0000_0000); rd(0);
    wrw(0, 32'h0000_003C); rd(0);
    cyc(0, 0, 0, 0, 0, 1, 0); rd(0);
    wrw(0, 32'h0000_0002); rd(0);
    wrw(0, 32'h0000_0040); rd(0);

    // R3: strobe and clear in the same cycle.
    cur_tag = "R3";
    cyc(1, 0, 32'h0000_0002, 0, 1, 0, 0); rd(0);
    cyc(1, 0, 32'h0000_0040, 0, 0, 1, 0); rd(0);
    wrw(0, 32'h0000_0042); rd(0);

    // R6: gate combinations on a pending source.
    cur_tag = "R6";
    cyc(0, 0, 0, 0, 1, 0, 0);
    wrw(1, 32'h0004_0002); rd(0);
    wrw(1, 32'h0008_0002); rd(0);
    wrw(1, 32'h000C_0002); rd(0);
    wrw(1, 32'h000C_00FD); rd(0);
    wrw(0, 32'h0000_00FF); rd(0);

    // R9: coalescing word with the expected programming.
    cur_tag = "R9";
    wrw(2, 32'h0800_0074); rd(2);
    wrw(2, 32'hFFFF_FFFF); rd(2);

    // R4: pending frames and the re-arming ready bit.
    cur_tag = "R4";
    wrw(2, 0); wrw(1, 32'h000C_0001);
    cyc(0, 0, 0, 1, 0, 0, 0); cyc(0, 0, 0, 1, 0, 0, 0); cyc(0, 0, 0, 1, 0, 0, 0);
    rd(0);
    for (int i = 0; i < 3; i++) begin wrw(0, 32'h1); rd(0); end
    wrw(0, 32'h1); rd(0);
    cyc(1, 0, 32'h1, 1, 0, 0, 0); rd(0);
    wrw(0, 32'h1); rd(0);

    // R7: threshold of three frames.
    cur_tag = "R7";
    wrw(1, 32'h000C_0080); wrw(2, 32'h0300_0000);
    cyc(0, 0, 0, 1, 0, 0, 0); cyc(0, 0, 0, 1, 0, 0, 0); rd(0);
    cyc(0, 0, 0, 1, 0, 0, 0); rd(0);
    wrw(0, 32'h80); rd(0);
    wrw(0, 32'h01); wrw(0, 32'h80); rd(0);
    wrw(0, 32'h01); wrw(0, 32'h01); rd(0);

    // R8: timeout of four ticks with a single frame.
    cur_tag = "R8";
    wrw(2, 32'h0000_0004);
    cyc(0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin cyc(0, 0, 0, 0, 0, 0, 1); rd(0); end
    cyc(0, 0, 0, 0, 0, 0, 1); rd(0);
    wrw(0, 32'h80);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, 1);
    rd(0);
    wrw(0, 32'h81); wrw(2, 0); rd(0);

    // R10: saturation of the pending count.
    cur_tag = "R10";
    for (int i = 0; i < 260; i++) cyc(0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 254; i++) wrw(0, 32'h1);
    rd(0);
    wrw(0, 32'h1); rd(0);

    // Random mix against the model.
    cur_tag = "random";
    for (int i = 0; i < 4000; i++) begin
      bit [1:0]  a;
      bit [31:0] d;
      bit        w;
      a = 2'($urandom_range(0, 3));
      w = ($urandom_range(0, 7) == 0);
      d = $urandom;
      if (w && a == 2'd2) d = {8'($urandom_range(0, 6)), 8'h00, 16'($urandom_range(0, 10))};
      if (w && a == 2'd1 && $urandom_range(0, 3) != 0) d[19:18] = 2'b11;
      cyc(w, a, d, ($urandom_range(0, 3) == 0), ($urandom_range(0, 15) == 0),
          ($urandom_range(0, 15) == 0), ($urandom_range(0, 2) == 0));
    end
    @(negedge clk);
    compare();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule